// File: doc/BRIEF.md
# Self-Clearing Engine Reset Sequencer

This block performs a software-requested reset of a whole DMA engine, taking its receive and transmit channel pipelines down together. Software writes a control word whose reset bit (bit `RST_BIT`, bit 0 by default) is 1. The sequencer then raises a status bit that software can read, a reset to the channel logic, and a reset output for logic outside the engine.

The reset is held until every channel has signalled that its pipeline is flushed, and for at least `MIN_HOLD` cycles. After that the status bit and the external reset fall in the same cycle, so software polls the bit until it reads 0. A flush-done pulse that arrives early in the sequence is remembered. While the reset is active, descriptor-completion reports from the channels are suppressed, because the descriptor in flight has to be treated as not completed. All pins are plain level or strobe signals and have no handshake.

Top module: `soft_reset_seq`

## Requirements
- R1: In idle, a clock edge with `ctrl_wr_en`=1 and `ctrl_wr_data[0]`=1 makes `rst_status` read 1 from the next cycle on.
- R2: `ch_reset` and `ext_reset_out` are 1 in exactly the cycles where `rst_status` is 1. They rise in the same cycle as the status bit.
- R3: The sequence does not end until each bit of `ch_flush_done` has been 1 in at least one active cycle. A one-cycle pulse is enough.
- R4: `rst_status` and `ext_reset_out` fall to 0 in the same cycle.
- R5: `rst_status` stays 1 for at least `MIN_HOLD` (4) cycles. If the last channel first reports flush-done in active cycle d (counting from 0), the active period lasts exactly max(4, d+1) cycles.
- R6: A write with bit 0 equal to 0 leaves the block idle. A write of 1 during an active sequence does not change the length of that sequence.
- R7: `desc_done_out` is 0 in every cycle where `rst_status` is 1. In every other cycle it equals `desc_done_in`.
- R8: While `rst_n` is 0, and right after it is released, the block is idle with all reset outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the streaming interface |
| rst_n | input | 1 | Hardware reset, active low |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | CTRL_W | Control register write data; bit RST_BIT requests the reset |
| ch_flush_done | input | NUM_CH | Per-channel pipeline-flushed indication |
| desc_done_in | input | 1 | Descriptor completion from the channels |
| rst_status | output | 1 | Readable self-clearing reset bit |
| ch_reset | output | 1 | Reset to the channel logic |
| ext_reset_out | output | 1 | Reset output for external logic |
| desc_done_out | output | 1 | Descriptor completion, masked during reset |

## Verification
The status bit and both reset outputs change one cycle after the clock edge that samples the write. The bench drives inputs at the falling edge and samples at the next falling edge, so active cycle 0 is the first sample after the write. Each active cycle is then counted at a falling edge, and the count is compared with max(4, d+1). The flush pulses for both channels are swept over active cycles 0 to 6. The completion mask is combinational from the status register, so it is checked at the same sample points as the status bit.

// File: rtl/soft_rst_pkg.sv
package soft_rst_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ACTIVE = 1'b1} seq_state_e;
endpackage

// File: rtl/rst_cmd_decode.sv
module rst_cmd_decode #(
  parameter int CTRL_W  = 32,
  parameter int RST_BIT = 0
) (
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              start_req
);
  logic unused_data;
  assign unused_data = ^wr_data;
  assign start_req = wr_en & wr_data[RST_BIT];
endmodule

// File: rtl/flush_tracker.sv
module flush_tracker #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [NUM_CH-1:0] flush_done,
  output logic              all_flushed
);
  logic [NUM_CH-1:0] seen_q;
  logic [NUM_CH-1:0] merged;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_q[i] <= 1'b0;
      else if (!active) seen_q[i] <= 1'b0;
      else              seen_q[i] <= seen_q[i] | flush_done[i];
    end
    assign merged[i] = seen_q[i] | flush_done[i];
  end

  assign all_flushed = &merged;

  // R3: a channel seen flushed stays recorded while the sequence runs
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && merged != '0 && $past(active)) |=> (!active || ((seen_q & $past(merged)) == $past(merged))));
endmodule

// File: rtl/rst_fsm.sv
module rst_fsm
  import soft_rst_pkg::*;
#(
  parameter int MIN_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic all_flushed,
  output logic busy_q,
  output logic busy_next
);
  localparam int CNT_W = (MIN_HOLD > 2) ? $clog2(MIN_HOLD) : 1;
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_HOLD - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] hold_cnt_q;
  logic hold_met;

  assign hold_met = (hold_cnt_q == HOLD_LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE:   if (start_req) state_d = SEQ_ACTIVE;
      SEQ_ACTIVE: if (hold_met && all_flushed) state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      hold_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_IDLE) hold_cnt_q <= '0;
      else if (!hold_met)      hold_cnt_q <= hold_cnt_q + 1'b1;
    end
  end

  assign busy_q    = (state_q == SEQ_ACTIVE);
  assign busy_next = (state_d == SEQ_ACTIVE);

  logic [7:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_len_q <= '0;
    else if (!busy_q)         run_len_q <= '0;
    else if (run_len_q != '1) run_len_q <= run_len_q + 1'b1;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_req) |=> busy_q);
  p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_req) |=> !busy_q);
  p_min_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(run_len_q) >= 8'(MIN_HOLD - 1)));
  p_flush_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(all_flushed));
endmodule

// File: rtl/soft_reset_seq.sv
module soft_reset_seq #(
  parameter int CTRL_W   = 32,
  parameter int RST_BIT  = 0,
  parameter int NUM_CH   = 2,
  parameter int MIN_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_en,
  input  logic [CTRL_W-1:0] ctrl_wr_data,
  input  logic [NUM_CH-1:0] ch_flush_done,
  input  logic              desc_done_in,
  output logic              rst_status,
  output logic              ch_reset,
  output logic              ext_reset_out,
  output logic              desc_done_out
);
  logic start_req, all_flushed, busy_q, busy_next, ext_q;

  rst_cmd_decode #(.CTRL_W(CTRL_W), .RST_BIT(RST_BIT)) u_decode (
    .wr_en(ctrl_wr_en), .wr_data(ctrl_wr_data), .start_req(start_req));

  flush_tracker #(.NUM_CH(NUM_CH)) u_flush (
    .clk(clk), .rst_n(rst_n), .active(busy_q),
    .flush_done(ch_flush_done), .all_flushed(all_flushed));

  rst_fsm #(.MIN_HOLD(MIN_HOLD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .all_flushed(all_flushed), .busy_q(busy_q), .busy_next(busy_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= busy_next;
  end

  assign rst_status    = busy_q;
  assign ch_reset      = busy_q;
  assign ext_reset_out = ext_q;
  assign desc_done_out = desc_done_in & ~busy_q;

  p_ext_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_reset_out == rst_status);
  p_joint_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_status) |-> $fell(ext_reset_out));
  p_desc_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_status |-> !desc_done_out);
endmodule

// File: tb/test_soft_reset_seq.sv
module test_soft_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAXD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr_en = 1'b0;
  logic [31:0] ctrl_wr_data = '0;
  logic [1:0] ch_flush_done = '0;
  logic desc_done_in = 1'b1;
  logic rst_status, ch_reset, ext_reset_out, desc_done_out;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_reset_seq i_soft_reset_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .ch_flush_done(ch_flush_done), .desc_done_in(desc_done_in),
    .rst_status(rst_status), .ch_reset(ch_reset), .ext_reset_out(ext_reset_out),
    .desc_done_out(desc_done_out));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int d0, input int d1, input bit retrig);
    int k, expd;
    @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = 32'h1;
    @(negedge clk); ctrl_wr_en = 1'b0; ctrl_wr_data = '0;
    chk("R1 status after write", int'(rst_status), 1);
    k = 0;
    while (rst_status && k < 40) begin
      chk("R2 ext tracks status", int'(ext_reset_out), 1);
      chk("R2 ch_reset tracks status", int'(ch_reset), 1);
      chk("R7 completion masked", int'(desc_done_out), 0);
      ch_flush_done[0] = (k == d0);
      ch_flush_done[1] = (k == d1);
      if (retrig && k == 1) begin ctrl_wr_en = 1'b1; ctrl_wr_data = 32'h1; end
      @(negedge clk);
      ctrl_wr_en = 1'b0; ctrl_wr_data = '0;
      k++;
    end
    ch_flush_done = '0;
    expd = (d0 > d1) ? d0 + 1 : d1 + 1;
    if (expd < 4) expd = 4;
    chk(retrig ? "R6 rewrite ignored, R3 R5 length" : "R3 R5 active length", k, expd);
    chk("R4 ext clears with status", int'(ext_reset_out), 0);
    chk("R7 completion passes when idle", int'(desc_done_out), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 status in reset", int'(rst_status), 0);
    chk("R8 ext in reset", int'(ext_reset_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", int'(rst_status), 0);
    chk("R8 ch_reset idle", int'(ch_reset), 0);

    // R6: write with reset bit 0 (other bits set)
    @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = 32'hFFFF_FFFE;
    @(negedge clk); ctrl_wr_en = 1'b0; ctrl_wr_data = '0;
    chk("R6 zero write ignored", int'(rst_status), 0);
    chk("R6 zero write ext", int'(ext_reset_out), 0);

    for (int d0 = 0; d0 <= MAXD; d0++)
      for (int d1 = 0; d1 <= MAXD; d1++)
        run_seq(d0, d1, ((d0 + d1) % 3) == 0);

    // R8: hardware reset in the middle of a sequence
    @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = 32'h1;
    @(negedge clk); ctrl_wr_en = 1'b0; ctrl_wr_data = '0;
    chk("R8 sequence started", int'(rst_status), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 forced idle status", int'(rst_status), 0);
    chk("R8 forced idle ext", int'(ext_reset_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 stays idle", int'(rst_status), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule